// File: doc/BRIEF.md
# Selectable-Form Right Shifter with Single-Step Slice Mode

This block is a purely combinational shifter for a small datapath word. A right shift can be taken through one of two structures. The first is a single-level crossbar steered by a decoded control word that has one line per shift distance. The second is a cascade of power-of-two stages steered by a binary shift amount. In both forms an arithmetic flag picks the fill for vacated high bits: zero, or copies of the word's top bit.

An operation code also reaches a per-bit-slice mode that moves the word by one position left or right, or passes it through unchanged. The block sits between a register file and a result bus. It has no storage, so the result follows the inputs within the same evaluation.

Top module: `shift_unit`

## Requirements
- R1: With `op` = 0 (crossbar form) and only line k of `sh_onehot` high, `result[i]` equals `data_in[i+k]` for every i with i+k < W.
- R2: Vacated high bits of every right shift (crossbar, cascade, single step) are 0 when `arith` = 0, and copies of `data_in[W-1]` when `arith` = 1.
- R3: In the crossbar form a control word with no line high gives `result` = 0; a control word with more than one line high is illegal and is flagged in simulation.
- R4: With `op` = 1 (cascade form), `result` equals `data_in` shifted right by the binary amount `sh_amt`, with stage s moving the word by 2^s positions when `sh_amt[s]` is 1.
- R5: For every amount k below W and both fill modes, the crossbar form with line k high and the cascade form with `sh_amt` = k give the same `result`.
- R6: With `op` = 3 (step right), `result[i]` = `data_in[i+1]` for i < W-1, and the top bit follows the R2 fill.
- R7: With `op` = 4 (step left), `result[i]` = `data_in[i-1]` for i > 0 and `result[0]` = 0 whatever `arith` is.
- R8: With `op` = 2 (hold), `result` equals `data_in`, and `arith`, `sh_onehot` and `sh_amt` have no effect.
- R9: The `op` codes 5, 6 and 7 are unused and drive `result` to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| data_in | input | W | Word to be shifted |
| sh_onehot | input | W | Decoded shift lines for the crossbar form, line k = distance k |
| sh_amt | input | $clog2(W) | Binary shift amount for the cascade form |
| arith | input | 1 | 1 = fill with the top data bit, 0 = fill with zero |
| op | input | 3 | 0 crossbar, 1 cascade, 2 hold, 3 step right, 4 step left, 5-7 zero |
| result | output | W | Shifted word |

## Verification
The block holds no state, so a wrong gate shows up at `result` in the same evaluation as the input that sensitizes it. A miswired crossbar tap or cascade stage corrupts only the shift amounts and data bits that route through it, and a fill error appears only on the vacated positions and only when the top data bit is 1. For that reason the sweep covers every data word with every amount, both fill modes and every operation code, and it compares the two forms with each other as well as with arithmetic references.

// File: rtl/shift_pkg.sv
package shift_pkg;

  typedef enum logic [2:0] {
    OP_BARREL = 3'd0,
    OP_LOG    = 3'd1,
    OP_HOLD   = 3'd2,
    OP_RIGHT  = 3'd3,
    OP_LEFT   = 3'd4
  } shift_op_e;

  typedef enum logic [1:0] {
    STEP_HOLD  = 2'd0,
    STEP_RIGHT = 2'd1,
    STEP_LEFT  = 2'd2
  } step_dir_e;

endpackage

// File: rtl/shift_barrel.sv
module shift_barrel #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] lines,
  input  logic         fill,
  output logic [W-1:0] y
);

  for (genvar i = 0; i < W; i++) begin : g_out
    logic [W-1:0] tap;
    for (genvar k = 0; k < W; k++) begin : g_tap
      if (i + k < W) begin : g_in
        assign tap[k] = lines[k] & a[i+k];
      end else begin : g_fill
        assign tap[k] = lines[k] & fill;
      end
    end
    assign y[i] = |tap;
  end

endmodule

// File: rtl/shift_log.sv
module shift_log #(
  parameter int W  = 8,
  parameter int AW = $clog2(W)
) (
  input  logic [W-1:0]  a,
  input  logic [AW-1:0] amt,
  input  logic          fill,
  output logic [W-1:0]  y
);

  logic [W-1:0] stage [0:AW];

  assign stage[0] = a;

  for (genvar s = 0; s < AW; s++) begin : g_stage
    localparam int DIST = 1 << s;
    for (genvar i = 0; i < W; i++) begin : g_bit
      if (i + DIST < W) begin : g_in
        assign stage[s+1][i] = amt[s] ? stage[s][i+DIST] : stage[s][i];
      end else begin : g_fill
        assign stage[s+1][i] = amt[s] ? fill : stage[s][i];
      end
    end
  end

  assign y = stage[AW];

endmodule

// File: rtl/shift_step.sv
module shift_step
  import shift_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  step_dir_e    dir,
  input  logic         fill,
  output logic [W-1:0] y
);

  for (genvar i = 0; i < W; i++) begin : g_slice
    logic from_hi;
    logic from_lo;
    if (i == W - 1) begin : g_top
      assign from_hi = fill;
    end else begin : g_mid_hi
      assign from_hi = a[i+1];
    end
    if (i == 0) begin : g_bot
      assign from_lo = 1'b0;
    end else begin : g_mid_lo
      assign from_lo = a[i-1];
    end
    always_comb begin
      unique case (dir)
        STEP_RIGHT: y[i] = from_hi;
        STEP_LEFT:  y[i] = from_lo;
        default:    y[i] = a[i];
      endcase
    end
  end

endmodule

// File: rtl/shift_unit.sv
module shift_unit
  import shift_pkg::*;
#(
  parameter int W  = 8,
  parameter int AW = $clog2(W)
) (
  input  logic [W-1:0]  data_in,
  input  logic [W-1:0]  sh_onehot,
  input  logic [AW-1:0] sh_amt,
  input  logic          arith,
  input  logic [2:0]    op,
  output logic [W-1:0]  result
);

  logic         fill;
  logic [W-1:0] y_barrel;
  logic [W-1:0] y_log;
  logic [W-1:0] y_step;
  step_dir_e    dir;

  assign fill = arith & data_in[W-1];

  always_comb begin
    unique case (op)
      OP_RIGHT: dir = STEP_RIGHT;
      OP_LEFT:  dir = STEP_LEFT;
      default:  dir = STEP_HOLD;
    endcase
  end

  shift_barrel #(.W(W)) u_barrel (
    .a     (data_in),
    .lines (sh_onehot),
    .fill  (fill),
    .y     (y_barrel)
  );

  shift_log #(.W(W), .AW(AW)) u_log (
    .a    (data_in),
    .amt  (sh_amt),
    .fill (fill),
    .y    (y_log)
  );

  shift_step #(.W(W)) u_step (
    .a    (data_in),
    .dir  (dir),
    .fill (fill),
    .y    (y_step)
  );

  always_comb begin
    unique case (op)
      OP_BARREL:                   result = y_barrel;
      OP_LOG:                      result = y_log;
      OP_HOLD, OP_RIGHT, OP_LEFT:  result = y_step;
      default:                     result = '0;
    endcase
  end

endmodule

// File: rtl/shift_unit_chk.sv
module shift_unit_chk #(
  parameter int W = 8
) (
  input logic [W-1:0] data_in,
  input logic [W-1:0] sh_onehot,
  input logic         arith,
  input logic [2:0]   op,
  input logic [W-1:0] result
);

  always_comb begin
    if (!$isunknown({data_in, sh_onehot, arith, op, result})) begin
      if (op == 3'd0) begin
        AST_BARREL_ONE_LINE: assert ($onehot0(sh_onehot)); // R3
      end
      if (op == 3'd0 && sh_onehot == '0) begin
        AST_BARREL_EMPTY_ZERO: assert (result == '0); // R3
      end
      if (op == 3'd2) begin
        AST_HOLD_PASS: assert (result == data_in); // R8
      end
      if (op > 3'd4) begin
        AST_UNUSED_OP_ZERO: assert (result == '0); // R9
      end
      if (op == 3'd4) begin
        AST_LEFT_LSB_ZERO: assert (result[0] == 1'b0 && result[W-1:1] == data_in[W-2:0]); // R7
      end
      if (arith && (op == 3'd1 || op == 3'd3 || (op == 3'd0 && sh_onehot != '0))) begin
        AST_SIGN_KEEP: assert (result[W-1] == data_in[W-1]); // R2
      end
      if (!arith && op == 3'd3) begin
        AST_RIGHT_ZERO_TOP: assert (result[W-1] == 1'b0 && result[W-2:0] == data_in[W-1:1]); // R6
      end
    end
  end

endmodule

bind shift_unit shift_unit_chk #(.W(W)) u_chk (
  .data_in   (data_in),
  .sh_onehot (sh_onehot),
  .arith     (arith),
  .op        (op),
  .result    (result)
);

// File: tb/shift_unit_tb.sv
module shift_unit_tb;

  localparam int W  = 8;
  localparam int AW = $clog2(W);

  logic          clk;
  logic          rst_n;
  logic [W-1:0]  data_in;
  logic [W-1:0]  sh_onehot;
  logic [AW-1:0] sh_amt;
  logic          arith;
  logic [2:0]    op;
  logic [W-1:0]  result;

  int n_checks;
  int n_fail;
  bit done;

  shift_unit #(.W(W)) u_dut (
    .data_in   (data_in),
    .sh_onehot (sh_onehot),
    .sh_amt    (sh_amt),
    .arith     (arith),
    .op        (op),
    .result    (result)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h (data %h op %0d arith %0d onehot %h amt %0d)",
               req, act, exp, data_in, op, arith, sh_onehot, sh_amt);
    end
  endtask

  function automatic logic [W-1:0] ref_right(input logic [W-1:0] d, input int k, input logic ar);
    logic [W-1:0] r;
    if (ar) r = W'($signed(d) >>> k);
    else    r = d >> k;
    return r;
  endfunction

  task automatic drive(input logic [W-1:0] d, input logic [W-1:0] oh,
                       input logic [AW-1:0] am, input logic ar, input logic [2:0] o);
    @(posedge clk);
    data_in   = d;
    sh_onehot = oh;
    sh_amt    = am;
    arith     = ar;
    op        = o;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] y_bar;
    n_checks  = 0;
    n_fail    = 0;
    done      = 1'b0;
    rst_n     = 1'b0;
    data_in   = '0;
    sh_onehot = '0;
    sh_amt    = '0;
    arith     = 1'b0;
    op        = 3'd0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R3: idle inputs, empty crossbar control gives zero
    check("R3 reset idle", result, '0);

    // R3: empty control with nonzero data, both fills
    drive(8'hA5, '0, '0, 1'b1, 3'd0);
    check("R3 empty control", result, '0);
    drive(8'hFF, '0, '0, 1'b0, 3'd0);
    check("R3 empty control", result, '0);

    // R1 R2 R4 R5: exhaustive sweep of both forms
    for (int d = 0; d < (1 << W); d++) begin
      for (int k = 0; k < W; k++) begin
        for (int ar = 0; ar < 2; ar++) begin
          drive(W'(d), W'(1) << k, '0, ar[0], 3'd0);
          y_bar = result;
          check(ar ? "R2 crossbar sign fill" : "R1 crossbar shift", result, ref_right(W'(d), k, ar[0]));
          drive(W'(d), '0, AW'(k), ar[0], 3'd1);
          check(ar ? "R2 cascade sign fill" : "R4 cascade shift", result, ref_right(W'(d), k, ar[0]));
          check("R5 forms agree", result, y_bar);
        end
      end
    end

    // R6 R7 R8: single-step slice modes
    for (int d = 0; d < (1 << W); d++) begin
      for (int ar = 0; ar < 2; ar++) begin
        drive(W'(d), 8'h81, 3'd5, ar[0], 3'd3);
        check("R6 step right", result, ref_right(W'(d), 1, ar[0]));
        drive(W'(d), 8'h81, 3'd5, ar[0], 3'd4);
        check("R7 step left", result, W'(d) << 1);
        drive(W'(d), W'(d), AW'(d), ar[0], 3'd2);
        check("R8 hold", result, W'(d));
      end
    end

    // R9: unused op codes
    for (int o = 5; o < 8; o++) begin
      drive(8'hC3, 8'h04, 3'd2, 1'b1, 3'(o));
      check("R9 unused op", result, '0);
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule